// File: doc/BRIEF.md
# Selectable Receive Sample Accumulator

This block sits in a multi-channel receive datapath between the sample deserializer and the sample buffer memory. It takes a time-multiplexed stream of 12-bit signed converter samples, each tagged with a channel number, and sign-extends every sample to a 16-bit word. Sixteen channels share one instance. Each clock cycle carries at most one sample.

The block can also sum groups of 2 or 4 consecutive samples of the same channel. This lowers the output rate by the same factor and improves signal-to-noise. Each channel keeps its own running sum and group counter in a register bank indexed by the incoming channel number. One output word, tagged with its channel, leaves the block when that channel's group is complete. The grouping factor is chosen at run time. When it changes, every channel restarts from an empty group, so a partial sum never reaches the buffer.

Top module: `rx_decim_accum`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0. All per-channel sums and group counts start empty, and the factor in force is 1.
- R2: With `mode_sel` = 0 (factor 1), every accepted sample produces an output one cycle later. That output carries the same channel and the sample sign-extended from 12 to 16 bits.
- R3: With `mode_sel` = 1 (factor 2), every second accepted sample of a channel produces an output one cycle later. The output holds the 16-bit sum of that sample and the previous one of the same channel. The first sample of the pair produces no output.
- R4: With `mode_sel` = 2 (factor 4), every fourth accepted sample of a channel produces an output one cycle later. The output holds the 16-bit sum of the four samples.
- R5: `mode_sel` = 3 behaves exactly as factor 1.
- R6: Each channel keeps its own sum and group count. Samples of other channels placed between them do not disturb them.
- R7: A cycle with `in_valid` low changes no sum and no count, and `out_valid` is 0 on the following cycle.
- R8: When `mode_sel` differs from the factor in force, all sums and counts are cleared and the new factor takes effect in that same cycle. A sample accepted in that cycle becomes the first of a new group. No partial sum from before the change is ever emitted.
- R9: Samples are two's complement. A sum of up to four samples always fits in 14 signed bits, so the 16-bit output never wraps. For example, four samples of -2048 give 0xE000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Datapath clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Grouping factor: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 1 |
| in_valid | input | 1 | Sample strobe |
| in_ch | input | 4 | Channel number of the incoming sample |
| in_data | input | 12 | Signed converter sample |
| out_valid | output | 1 | Output word strobe |
| out_ch | output | 4 | Channel number of the output word |
| out_data | output | 16 | Sign-extended sample or group sum |

## Verification
The properties assume that `in_valid`, `in_ch`, `in_data` and `mode_sel` are known (never X) at every clock edge after reset. They also assume that `mode_sel` is an input sampled in the same cycle as the sample it governs. The bench drives all inputs on the falling edge and parks them at defined values during idle cycles, so these assumptions hold. Every factor change in the bench is made at a cycle the bench chooses, and the bench checks the following output against sums it computes itself from fresh groups.

// File: rtl/rxacc_pkg.sv
package rxacc_pkg;

   localparam int unsigned GRP_MAX = 4;
   localparam int unsigned GRP_CW  = $clog2(GRP_MAX);

   typedef enum logic [1:0] {
      GRP_ONE   = 2'd0,
      GRP_TWO   = 2'd1,
      GRP_FOUR  = 2'd2,
      GRP_ONE_B = 2'd3
   } grp_mode_e;

   // index of the final sample within a group for a given mode
   function automatic logic [GRP_CW-1:0] grp_last_idx(input logic [1:0] m);
      case (m)
         GRP_TWO:  grp_last_idx = GRP_CW'(1);
         GRP_FOUR: grp_last_idx = GRP_CW'(3);
         default:  grp_last_idx = '0;
      endcase
   endfunction

endpackage

// File: rtl/rxacc_widen.sv
module rxacc_widen #(
   parameter int unsigned IN_W      = 12,
   parameter int unsigned OUT_W     = 16,
   parameter bit          SIGNED_IN = 1'b1
) (
   input  logic [IN_W-1:0]  raw_i,
   output logic [OUT_W-1:0] wide_o
);
   localparam int unsigned EXT_W = OUT_W - IN_W;

   generate
      if (OUT_W <= IN_W) begin : g_bad
         $error("rxacc_widen: OUT_W must exceed IN_W");
      end
      if (SIGNED_IN) begin : g_sext
         assign wide_o = {{EXT_W{raw_i[IN_W-1]}}, raw_i};
      end else begin : g_zext
         assign wide_o = {{EXT_W{1'b0}}, raw_i};
      end
   endgenerate
endmodule

// File: rtl/rxacc_lane_bank.sv
module rxacc_lane_bank
   import rxacc_pkg::*;
#(
   parameter int unsigned NCH   = 16,
   parameter int unsigned SUM_W = 16,
   localparam int unsigned CHW  = $clog2(NCH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic [1:0]       mode_i,
   input  logic             hit_i,
   input  logic [CHW-1:0]   ch_i,
   input  logic [SUM_W-1:0] wide_i,
   output logic [SUM_W-1:0] sum_o,
   output logic             last_o
);
   logic [SUM_W-1:0]  acc_q [NCH];
   logic [GRP_CW-1:0] cnt_q [NCH];
   logic [SUM_W-1:0]  base_acc;
   logic [GRP_CW-1:0] base_cnt;

   always_comb begin
      base_acc = flush_i ? '0 : acc_q[ch_i];
      base_cnt = flush_i ? '0 : cnt_q[ch_i];
      sum_o    = base_acc + wide_i;
      last_o   = (base_cnt == grp_last_idx(mode_i));
   end

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_lane
         logic sel;
         assign sel = hit_i && (ch_i == CHW'(g));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               acc_q[g] <= '0;
               cnt_q[g] <= '0;
            end else if (sel) begin
               if (last_o) begin
                  acc_q[g] <= '0;
                  cnt_q[g] <= '0;
               end else begin
                  acc_q[g] <= sum_o;
                  cnt_q[g] <= base_cnt + GRP_CW'(1);
               end
            end else if (flush_i) begin
               acc_q[g] <= '0;
               cnt_q[g] <= '0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/rx_decim_accum.sv
module rx_decim_accum
   import rxacc_pkg::*;
#(
   parameter int unsigned NCH   = 16,
   parameter int unsigned IN_W  = 12,
   parameter int unsigned OUT_W = 16,
   localparam int unsigned CHW  = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode_sel,
   input  logic              in_valid,
   input  logic [CHW-1:0]    in_ch,
   input  logic [IN_W-1:0]   in_data,
   output logic              out_valid,
   output logic [CHW-1:0]    out_ch,
   output logic [OUT_W-1:0]  out_data
);
   generate
      if (OUT_W < IN_W + GRP_CW) begin : g_width_chk
         $error("rx_decim_accum: OUT_W too narrow for group sums");
      end
      if (NCH < 2) begin : g_nch_chk
         $error("rx_decim_accum: NCH must be at least 2");
      end
   endgenerate

   logic [1:0]       mode_q;
   logic             flush;
   logic [OUT_W-1:0] wide;
   logic [OUT_W-1:0] sum;
   logic             last;

   assign flush = (mode_sel != mode_q);

   rxacc_widen #(.IN_W(IN_W), .OUT_W(OUT_W), .SIGNED_IN(1'b1)) u_widen (
      .raw_i  (in_data),
      .wide_o (wide)
   );

   rxacc_lane_bank #(.NCH(NCH), .SUM_W(OUT_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (flush),
      .mode_i  (mode_sel),
      .hit_i   (in_valid),
      .ch_i    (in_ch),
      .wide_i  (wide),
      .sum_o   (sum),
      .last_o  (last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= GRP_ONE;
         out_valid <= 1'b0;
         out_ch    <= '0;
         out_data  <= '0;
      end else begin
         mode_q    <= mode_sel;
         out_valid <= in_valid && last;
         if (in_valid && last) begin
            out_ch   <= in_ch;
            out_data <= sum;
         end
      end
   end
endmodule

// File: rtl/rx_decim_accum_chk.sv
module rx_decim_accum_chk #(
   parameter int unsigned CHW   = 4,
   parameter int unsigned IN_W  = 12,
   parameter int unsigned OUT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode_sel,
   input logic             in_valid,
   input logic [CHW-1:0]   in_ch,
   input logic [IN_W-1:0]  in_data,
   input logic             out_valid,
   input logic [CHW-1:0]   out_ch,
   input logic [OUT_W-1:0] out_data
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> !out_valid);

   // R2
   pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (mode_sel == 2'd0 || mode_sel == 2'd3)) |=>
         (out_valid && out_ch == $past(in_ch) &&
          $signed(out_data) == OUT_W'($signed($past(in_data)))));

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data[OUT_W-1:IN_W+1] == '0 || out_data[OUT_W-1:IN_W+1] == '1));

   // R3
   pair_never_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_sel == 2'd1 && $past(mode_sel) != 2'd1) |=> !out_valid);
endmodule

bind rx_decim_accum rx_decim_accum_chk #(.CHW(CHW), .IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_sel  (mode_sel),
   .in_valid  (in_valid),
   .in_ch     (in_ch),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_ch    (out_ch),
   .out_data  (out_data)
);

// File: tb/sim_rx_decim_accum.sv
module sim_rx_decim_accum;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  mode_sel;
   logic        in_valid;
   logic [3:0]  in_ch;
   logic [11:0] in_data;
   logic        out_valid;
   logic [3:0]  out_ch;
   logic [15:0] out_data;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   rx_decim_accum u0 (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .in_valid(in_valid),
      .in_ch(in_ch), .in_data(in_data), .out_valid(out_valid),
      .out_ch(out_ch), .out_data(out_data)
   );

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 5000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 5000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   // apply one cycle of input; on return the registered output for it is visible
   task automatic step(input logic v, input int ch, input int d, input logic [1:0] m);
      in_valid = v;
      in_ch    = 4'(ch);
      in_data  = 12'(d);
      mode_sel = m;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic expect_out(input string req, input logic v, input int ch, input int d);
      logic [15:0] ed;
      ed = 16'(d);
      checks++;
      if (out_valid !== v || (v && (out_ch !== 4'(ch) || out_data !== ed))) begin
         errors++;
         $display("FAIL %s: actual valid=%0b ch=%0d data=%h expected valid=%0b ch=%0d data=%h",
                  req, out_valid, out_ch, out_data, v, ch, ed);
      end
   endtask

   task automatic t_reset();
      // R1
      expect_out("R1", 1'b0, 0, 0);
      step(1'b0, 0, 0, 2'd0);
      expect_out("R1", 1'b0, 0, 0);
   endtask

   task automatic t_factor_one();
      // R2 / R9 sign extension
      step(1'b1, 3, 12'h7FF, 2'd0);
      expect_out("R2", 1'b1, 3, 2047);
      step(1'b1, 5, 12'h800, 2'd0);
      expect_out("R2", 1'b1, 5, -2048);
      step(1'b1, 15, 12'hFFF, 2'd0);
      expect_out("R2", 1'b1, 15, -1);
   endtask

   task automatic t_factor_one_alt();
      // R5
      step(1'b1, 1, 12'h123, 2'd3);
      expect_out("R5", 1'b1, 1, 16'h0123);
      step(1'b1, 9, 12'hF00, 2'd3);
      expect_out("R5", 1'b1, 9, -256);
   endtask

   task automatic t_factor_two();
      // R3
      step(1'b1, 2, 100, 2'd1);
      expect_out("R3", 1'b0, 0, 0);
      step(1'b1, 2, 200, 2'd1);
      expect_out("R3", 1'b1, 2, 300);
      // R6 interleaved channels
      step(1'b1, 0, 10, 2'd1);
      expect_out("R6", 1'b0, 0, 0);
      step(1'b1, 1, -5, 2'd1);
      expect_out("R6", 1'b0, 0, 0);
      step(1'b1, 0, 20, 2'd1);
      expect_out("R6", 1'b1, 0, 30);
      step(1'b1, 1, -7, 2'd1);
      expect_out("R6", 1'b1, 1, -12);
   endtask

   task automatic t_factor_four();
      // R4 / R9 most negative group
      for (int k = 0; k < 3; k++) begin
         step(1'b1, 7, 12'h800, 2'd2);
         expect_out("R4", 1'b0, 0, 0);
      end
      step(1'b1, 7, 12'h800, 2'd2);
      expect_out("R9", 1'b1, 7, 16'hE000);
      for (int k = 0; k < 4; k++) step(1'b1, 12, 2047, 2'd2);
      expect_out("R4", 1'b1, 12, 8188);
   endtask

   task automatic t_gaps();
      // R7
      step(1'b1, 4, 1, 2'd2);
      step(1'b0, 4, 999, 2'd2);
      expect_out("R7", 1'b0, 0, 0);
      step(1'b1, 4, 2, 2'd2);
      step(1'b0, 4, 555, 2'd2);
      expect_out("R7", 1'b0, 0, 0);
      step(1'b1, 4, 3, 2'd2);
      step(1'b1, 4, 4, 2'd2);
      expect_out("R7", 1'b1, 4, 10);
   endtask

   task automatic t_switch();
      // R8
      step(1'b1, 6, 50, 2'd1);
      expect_out("R8", 1'b0, 0, 0);
      step(1'b1, 6, 1, 2'd2);
      expect_out("R8", 1'b0, 0, 0);
      step(1'b1, 6, 1, 2'd2);
      step(1'b1, 6, 1, 2'd2);
      expect_out("R8", 1'b0, 0, 0);
      step(1'b1, 6, 1, 2'd2);
      expect_out("R8", 1'b1, 6, 4);
      // partial pair abandoned by switching to factor 1 and back
      step(1'b1, 8, 70, 2'd1);
      step(1'b0, 8, 0, 2'd0);
      expect_out("R8", 1'b0, 0, 0);
      step(1'b1, 8, 5, 2'd1);
      expect_out("R8", 1'b0, 0, 0);
      step(1'b1, 8, 6, 2'd1);
      expect_out("R8", 1'b1, 8, 11);
   endtask

   initial begin
      rst_n    = 1'b0;
      mode_sel = 2'd0;
      in_valid = 1'b0;
      in_ch    = '0;
      in_data  = '0;
      repeat (3) @(negedge clk);
      expect_out("R1", 1'b0, 0, 0);
      rst_n = 1'b1;
      t_reset();
      t_factor_one();
      t_factor_one_alt();
      t_factor_two();
      t_factor_four();
      t_gaps();
      t_switch();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule